// File: doc/BRIEF.md
# Programmable Sync Interval Pulse Generator

This block produces a periodic sync pulse for a receive path. A 32-bit counter runs on the receive clock. When the count reaches a programmed interval, the counter goes back to zero and a pulse starts. The pulse lasts a programmable number of cycles. Several downstream blocks can use the pulse as their shared timing reference.

Software programs the block through a small write port. Four word addresses hold:

- the two 16-bit halves of the interval,
- the pulse width,
- the choice of restart source.

One of seven external sync inputs can be chosen as the restart source. While the chosen input is high, the counter is held at zero and any pulse in progress is stopped. This lets the generated pulse train line up with a system-wide event.

Top module: `sync_interval_gen`

## Requirements
- R1: After reset, both interval halves hold 65535, the width field holds 0, the restart select holds 0, the counter is 0 and `pulse_o` is low.
- R2: When no restart is active and the count is not equal to the interval, the counter advances by exactly one on every rising clock edge.
- R3: When the count equals the interval, the counter reloads to zero and `pulse_o` rises on that same edge. After a restart ends, the first pulse appears I+1 cycles later, and pulses then repeat every I+1 cycles.
- R4: A write to address 2 stores `wdata_i[7:0]` as width field W, and each pulse then lasts W+1 cycles (1 to 256).
- R5: When W+1 is at least the period I+1, `pulse_o` stays high continuously while the counter keeps wrapping.
- R6: A write to address 3 stores `wdata_i[2:0]` as select S. For S from 1 to 7, while `sync_i[S-1]` is high, the counter is held at zero and `pulse_o` is driven low on the next edge.
- R7: With S = 0, no input restarts the counter. For any S, the inputs that S does not select have no effect.
- R8: A write to address 1 only stages the high 16 bits of the interval. A write to address 0 loads the full interval as {staged high, `wdata_i`}. The active interval therefore never changes on a high-half write alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| sync_i | input | 7 | Candidate restart sources |
| pulse_o | output | 1 | Generated sync pulse |

## Verification
The bench builds the block with its default parameters: 16-bit halves, an 8-bit width field and a 3-bit select.

Because the interval is fully programmable, small values reach many wraps within a short run. A vector table covers the following cases:

- one-cycle pulses,
- multi-cycle pulses,
- pulses wider than the period,
- intervals of zero and one.

Directed cases then cover:

- the full 256-cycle width,
- an interval above 65535, which uses the high half,
- a staged high write that is not yet committed,
- cancellation of a pulse mid-way,
- immunity to unselected inputs.

// File: rtl/sync_interval_gen.sv
module sync_interval_gen #(
  parameter int HALF_W  = 16,
  parameter int WIDTH_W = 8,
  parameter int SEL_W   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              addr_i,
  input  logic [HALF_W-1:0]       wdata_i,
  input  logic                    we_i,
  input  logic [(2**SEL_W)-2:0]   sync_i,
  output logic                    pulse_o
);
  localparam int CNT_W = 2 * HALF_W;
  localparam int NSRC  = 2 ** SEL_W;

  logic [HALF_W-1:0]  hi_stage_q;
  logic [CNT_W-1:0]   interval_q;
  logic [WIDTH_W-1:0] width_q;
  logic [SEL_W-1:0]   sel_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WIDTH_W-1:0] rem_q;
  logic               pulse_q;

  logic [NSRC-1:0] src;
  logic            restart;
  logic            hit;

  assign src     = {sync_i, 1'b0};
  assign restart = src[sel_q];
  assign hit     = !restart && (cnt_q == interval_q);
  assign pulse_o = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_stage_q <= {HALF_W{1'b1}};
      interval_q <= {CNT_W{1'b1}};
      width_q    <= '0;
      sel_q      <= '0;
    end else if (we_i) begin
      case (addr_i)
        2'd0: interval_q <= {hi_stage_q, wdata_i};
        2'd1: hi_stage_q <= wdata_i;
        2'd2: width_q    <= wdata_i[WIDTH_W-1:0];
        default: sel_q   <= wdata_i[SEL_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rem_q   <= '0;
      pulse_q <= 1'b0;
    end else if (restart) begin
      cnt_q   <= '0;
      rem_q   <= '0;
      pulse_q <= 1'b0;
    end else if (hit) begin
      cnt_q   <= '0;
      rem_q   <= width_q;
      pulse_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (pulse_q) begin
        if (rem_q == '0) pulse_q <= 1'b0;
        else             rem_q   <= rem_q - WIDTH_W'(1);
      end
    end
  end

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart && cnt_q != interval_q) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r3_wrap_starts_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (cnt_q == '0) && pulse_o);

  a_r4_pulse_ends_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> ($past(restart) || $past(rem_q) == '0));

  a_r6_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (cnt_q == '0) && !pulse_o);

  a_r8_high_write_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1) |=> $stable(interval_q));
endmodule

// File: tb/test_sync_interval_gen.sv
module test_sync_interval_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [6:0]  sync = '0;
  logic        pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  sync_interval_gen i_sync_interval_gen (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .sync_i(sync), .pulse_o(pulse)
  );

  always #5 clk = ~clk;

  // {interval[15:0], width[7:0], latency[15:0], highs over 3 periods[15:0]}
  localparam logic [55:0] VEC [8] = '{
    {16'd5,  8'd0, 16'd6,  16'd3},
    {16'd5,  8'd2, 16'd6,  16'd9},
    {16'd9,  8'd3, 16'd10, 16'd12},
    {16'd3,  8'd7, 16'd4,  16'd12},
    {16'd0,  8'd0, 16'd1,  16'd3},
    {16'd1,  8'd0, 16'd2,  16'd3},
    {16'd20, 8'd9, 16'd21, 16'd30},
    {16'd2,  8'd1, 16'd3,  16'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic restart_via0();
    wr(2'd3, 16'd1);
    sync[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sync[0] = 1'b0;
  endtask

  task automatic latency(output int n, input int limit);
    n = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      n++;
      if (pulse) break;
    end
  endtask

  task automatic count_highs(output int h, input int win);
    h = pulse ? 1 : 0;
    for (int k = 1; k < win; k++) begin
      @(negedge clk);
      if (pulse) h++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat, hi, ifv, wv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: pulse low after reset, 65535:65535 interval never reached soon
    count_highs(hi, 200);
    chk("R1 pulse low after reset", hi, 0);
    // R1: width defaults to 0 -> one-cycle pulses
    wr(2'd1, 16'd0); wr(2'd0, 16'd4);
    restart_via0();
    latency(lat, 50);
    chk("R1 default width latency", lat, 5);
    count_highs(hi, 15);
    chk("R1 default width one cycle", hi, 3);

    // R2 R3 R4 R5: vector table
    foreach (VEC[i]) begin
      ifv = int'(VEC[i][55:40]);
      wv  = int'(VEC[i][39:32]);
      wr(2'd1, 16'd0); wr(2'd0, VEC[i][55:40]); wr(2'd2, {8'd0, VEC[i][39:32]});
      restart_via0();
      latency(lat, 1000);
      chk($sformatf("R2 R3 latency I=%0d W=%0d", ifv, wv), lat, int'(VEC[i][31:16]));
      count_highs(hi, 3 * (ifv + 1));
      chk($sformatf("R4 R5 highs I=%0d W=%0d", ifv, wv), hi, int'(VEC[i][15:0]));
    end

    // R4: full 256-cycle width
    wr(2'd0, 16'd300); wr(2'd2, 16'd255);
    restart_via0();
    latency(lat, 1000);
    chk("R4 latency I=300", lat, 301);
    count_highs(hi, 301);
    chk("R4 width 255 gives 256 cycles", hi, 256);

    // R8: staged high write does not change active interval
    wr(2'd2, 16'd0); wr(2'd1, 16'd0); wr(2'd0, 16'd5);
    wr(2'd1, 16'd1);
    restart_via0();
    latency(lat, 1000);
    chk("R8 high write alone ignored", lat, 6);
    // R8: commit with low write -> interval 65536
    wr(2'd0, 16'd0);
    restart_via0();
    latency(lat, 70000);
    chk("R8 committed interval 65536", lat, 65537);

    // R6: restart cancels pulse in progress
    wr(2'd1, 16'd0); wr(2'd0, 16'd20); wr(2'd2, 16'd9);
    restart_via0();
    latency(lat, 100);
    @(negedge clk); @(negedge clk);
    chk("R6 pulse high before cancel", int'(pulse), 1);
    sync[0] = 1'b1;
    @(negedge clk);
    chk("R6 pulse cancelled", int'(pulse), 0);
    count_highs(hi, 40);
    chk("R6 held while sync high", hi, 0);
    sync[0] = 1'b0;
    latency(lat, 100);
    chk("R6 realigned latency", lat, 21);

    // R7: select 0 ignores all inputs
    wr(2'd0, 16'd5); wr(2'd2, 16'd0);
    restart_via0();
    wr(2'd3, 16'd0);
    sync = 7'h7f;
    @(negedge clk);
    count_highs(hi, 18);
    chk("R7 select 0 no restart", hi, 3);
    sync = '0;
    // R7: unselected input ignored, selected input 2 holds
    wr(2'd3, 16'd2);
    sync[0] = 1'b1;
    @(negedge clk);
    count_highs(hi, 18);
    chk("R7 unselected input ignored", hi, 3);
    sync[1] = 1'b1;
    @(negedge clk);
    count_highs(hi, 18);
    chk("R6 select 2 holds counter", hi, 0);
    sync = '0;
    latency(lat, 100);
    chk("R6 select 2 realign", lat, 6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule